// File: doc/BRIEF.md
# Trap Entry Unit

This block owns the trap-related machine state of a processor core and sequences every entry into a handler. Each clock it looks at four kinds of request. A debug breakpoint is checked first, then a synchronous exception with a cause and subcause, then level-sensitive external interrupt lines. Because a refill fault and an ordinary fault are saved differently, the refill-in-progress flag picks between two save paths. Each clock the unit picks at most one request. It updates the mode, status, saved-mode, return-address, bad-address and bad-instruction state, and it registers the redirected program counter.

The handler address is the entry base plus a multiple of a programmable vector spacing. An interrupt uses the slot that follows the exception codes (base code 64 plus the line number). A synchronous exception uses its major cause code. A refill fault jumps to its own entry address. A debug entry jumps to the entry base plus 0x480, and it has its own return register and cause flags. The pipeline supplies the current PC and the fetched instruction word. Software writes the mode and the vector configuration through a narrow write port. The register-access decoding sits outside this unit.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset: next_pc = 0x1C000000, plv = 0, ie = 0, da = 1, pg = 0, vs = 0, lie = 0, debug state 0, redirect = 0, irq_taken = 0.
- R2: int_status follows irq_lines one clock later. Each bit follows its own line and falls as soon as its line falls, so nothing is held.
- R3: An interrupt is taken only when ie = 1, the debug state is 0 and (int_status & lie) is nonzero. When it is taken, irq_taken pulses for one cycle.
- R4: Among the enabled pending lines, the highest-numbered one selects the vector.
- R5: The spacing is 0 when vs = 0 and (4 << vs) bytes otherwise. An interrupt enters at entry_base + (64 + line) × spacing. It writes cause 0 and subcause 0.
- R6: A non-refill exception enters at entry_base + exc_code × spacing. It writes exc_code into cause and exc_sub into subcause, copies plv/ie into saved_plv/saved_ie, and stores cur_pc in ret_addr.
- R7: Every entry that is not a debug entry clears plv and ie to 0 in the same clock edge.
- R8: Exception codes 11 to 18 inclusive load cur_pc into bad_addr. Every other code, and every interrupt, leaves bad_addr unchanged.
- R9: Exceptions load fetch_word into bad_instr, with three exceptions that leave it unchanged: code 0, code 3, and code 8 with subcode 0. Interrupts also leave it unchanged.
- R10: When refill_active is 1, an exception entry does four things. It copies plv/ie into rf_saved_plv/rf_saved_ie. It sets da = 1 and pg = 0. It stores cur_pc >> 2 in rf_ret. It enters at refill_entry. In this case cause, subcause and ret_addr are left unchanged.
- R11: A debug breakpoint sets dbg_cause_brk, writes dbg_code = 0xC, stores cur_pc in dbg_ret, sets dbg_active and enters at entry_base + 0x480. It leaves plv, ie and cause unchanged.
- R12: When dbg_active is set, an enabled pending interrupt does not take the normal path. It sets dbg_cause_int, stores cur_pc in dbg_ret and enters at entry_base + 0x480. irq_taken stays 0 and the normal status is not touched.
- R13: Requests are taken in this order: debug breakpoint, then exception, then interrupt. Every entry shows up one clock after the request as a registered next_pc with redirect = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 6 | Major cause code |
| exc_sub | input | 9 | Cause subcode |
| refill_active | input | 1 | Refill fault in progress |
| dbg_brk | input | 1 | Debug breakpoint request |
| irq_lines | input | NIRQ | Level-sensitive interrupt lines |
| cur_pc | input | XLEN | PC of the current instruction |
| fetch_word | input | 32 | Instruction word at cur_pc |
| entry_base | input | XLEN | Handler base address |
| refill_entry | input | XLEN | Refill handler address |
| mode_we | input | 1 | Write the mode fields below |
| mode_plv | input | 2 | New privilege level |
| mode_ie | input | 1 | New global interrupt enable |
| mode_da | input | 1 | New direct-address flag |
| mode_pg | input | 1 | New paging flag |
| cfg_we | input | 1 | Write vector configuration |
| cfg_vs | input | VSW | New vector-size field |
| cfg_lie | input | NIRQ | New local enable mask |
| redirect | output | 1 | next_pc was updated by an entry |
| irq_taken | output | 1 | Normal interrupt entry this cycle |
| next_pc | output | XLEN | Redirected PC |
| plv | output | 2 | Current privilege level |
| ie | output | 1 | Global interrupt enable |
| da | output | 1 | Direct-address mode |
| pg | output | 1 | Paging enable |
| vs | output | VSW | Vector-size field |
| lie | output | NIRQ | Local enable mask |
| int_status | output | NIRQ | Interrupt status bits |
| cause | output | 6 | Recorded major code |
| subcause | output | 9 | Recorded subcode |
| saved_plv | output | 2 | Saved privilege level |
| saved_ie | output | 1 | Saved interrupt enable |
| ret_addr | output | XLEN | Exception return address |
| bad_addr | output | XLEN | Bad address |
| bad_instr | output | 32 | Faulting instruction word |
| rf_saved_plv | output | 2 | Refill saved privilege level |
| rf_saved_ie | output | 1 | Refill saved interrupt enable |
| rf_ret | output | XLEN | Refill return PC, word index |
| dbg_active | output | 1 | Debug state flag |
| dbg_cause_brk | output | 1 | Debug entered by breakpoint |
| dbg_cause_int | output | 1 | Debug entered by interrupt |
| dbg_code | output | 6 | Debug cause code |
| dbg_ret | output | XLEN | Debug return address |

## Verification
The interrupt sweep sets one line at each index and adds pattern bits on the lower lines, and it repeats this for every vector size. This shows that the highest line wins and that the spacing arithmetic is right, including spacing zero. Runs where the mask hides the top lines, where the mask is zero and where ie is zero separate a correct masking gate from a plain OR of the lines. The exception sweep covers every cause code 0 to 18 with subcodes 0 and 1, and so tests both capture-class boundaries. Collision cases, the refill path and the debug paths show which request wins and which save registers each path is allowed to touch.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN = 32,
  parameter int NIRQ = 8,
  parameter int VSW = 3,
  parameter int IRQ_BASE = 64,
  parameter logic [XLEN-1:0] RESET_PC = 32'h1C00_0000,
  parameter logic [XLEN-1:0] DBG_OFS = 32'h480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [5:0]      exc_code,
  input  logic [8:0]      exc_sub,
  input  logic            refill_active,
  input  logic            dbg_brk,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [31:0]     fetch_word,
  input  logic [XLEN-1:0] entry_base,
  input  logic [XLEN-1:0] refill_entry,
  input  logic            mode_we,
  input  logic [1:0]      mode_plv,
  input  logic            mode_ie,
  input  logic            mode_da,
  input  logic            mode_pg,
  input  logic            cfg_we,
  input  logic [VSW-1:0]  cfg_vs,
  input  logic [NIRQ-1:0] cfg_lie,
  output logic            redirect,
  output logic            irq_taken,
  output logic [XLEN-1:0] next_pc,
  output logic [1:0]      plv,
  output logic            ie,
  output logic            da,
  output logic            pg,
  output logic [VSW-1:0]  vs,
  output logic [NIRQ-1:0] lie,
  output logic [NIRQ-1:0] int_status,
  output logic [5:0]      cause,
  output logic [8:0]      subcause,
  output logic [1:0]      saved_plv,
  output logic            saved_ie,
  output logic [XLEN-1:0] ret_addr,
  output logic [XLEN-1:0] bad_addr,
  output logic [31:0]     bad_instr,
  output logic [1:0]      rf_saved_plv,
  output logic            rf_saved_ie,
  output logic [XLEN-1:0] rf_ret,
  output logic            dbg_active,
  output logic            dbg_cause_brk,
  output logic            dbg_cause_int,
  output logic [5:0]      dbg_code,
  output logic [XLEN-1:0] dbg_ret
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic [NIRQ-1:0] enabled;
  logic [IW-1:0]   win;
  logic [XLEN-1:0] spacing, target;
  logic int_ok, take_dbg, take_exc, take_int, take_dint, normal, cap_badv, cap_badi;

  assign enabled  = int_status & lie;
  assign int_ok   = ie && (|enabled);
  assign take_dbg = dbg_brk;
  assign take_exc = !dbg_brk && exc_req;
  assign take_int = !dbg_brk && !exc_req && int_ok && !dbg_active;
  assign take_dint = !dbg_brk && !exc_req && int_ok && dbg_active;
  assign normal   = take_exc || take_int;
  assign spacing  = (vs == '0) ? '0 : (XLEN'(4) << vs);
  assign cap_badv = take_exc && exc_code >= 6'd11 && exc_code <= 6'd18;
  assign cap_badi = take_exc && !(exc_code == 6'd0 || exc_code == 6'd3 ||
                                  (exc_code == 6'd8 && exc_sub == 9'd0));

  always_comb begin
    win = '0;
    for (int i = 0; i < NIRQ; i++)
      if (enabled[i]) win = IW'(i);
  end

  always_comb begin
    if (take_dbg || take_dint)        target = entry_base + DBG_OFS;
    else if (take_int)                target = entry_base + (XLEN'(IRQ_BASE) + XLEN'(win)) * spacing;
    else if (refill_active)           target = refill_entry;
    else                              target = entry_base + XLEN'(exc_code) * spacing;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect <= 1'b0;  irq_taken <= 1'b0;  next_pc <= RESET_PC;
      plv <= '0;  ie <= 1'b0;  da <= 1'b1;  pg <= 1'b0;
      vs <= '0;  lie <= '0;  int_status <= '0;
      cause <= '0;  subcause <= '0;  saved_plv <= '0;  saved_ie <= 1'b0;
      ret_addr <= '0;  bad_addr <= '0;  bad_instr <= '0;
      rf_saved_plv <= '0;  rf_saved_ie <= 1'b0;  rf_ret <= '0;
      dbg_active <= 1'b0;  dbg_cause_brk <= 1'b0;  dbg_cause_int <= 1'b0;
      dbg_code <= '0;  dbg_ret <= '0;
    end else begin
      int_status <= irq_lines;
      irq_taken  <= take_int;
      redirect   <= take_dbg || take_dint || normal;
      if (cfg_we) begin
        vs <= cfg_vs;  lie <= cfg_lie;
      end
      if (mode_we && !normal) begin
        plv <= mode_plv;  ie <= mode_ie;
      end
      if (mode_we && !(normal && refill_active)) begin
        da <= mode_da;  pg <= mode_pg;
      end
      if (take_dbg || take_dint) begin
        next_pc <= target;
        dbg_ret <= cur_pc;
        dbg_active <= 1'b1;
        if (take_dbg) begin
          dbg_cause_brk <= 1'b1;  dbg_code <= 6'hC;
        end else
          dbg_cause_int <= 1'b1;
      end
      if (normal) begin
        next_pc <= target;
        plv <= '0;  ie <= 1'b0;
        if (refill_active) begin
          rf_saved_plv <= plv;  rf_saved_ie <= ie;
          da <= 1'b1;  pg <= 1'b0;
          rf_ret <= cur_pc >> 2;
        end else begin
          cause    <= take_int ? 6'd0 : exc_code;
          subcause <= take_int ? 9'd0 : exc_sub;
          saved_plv <= plv;  saved_ie <= ie;
          ret_addr <= cur_pc;
        end
        if (cap_badv) bad_addr <= cur_pc;
        if (cap_badi) bad_instr <= fetch_word;
      end
    end
  end

  assert_status_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int_status == $past(irq_lines));
  assert_taken_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> ($past(ie) && !$past(dbg_active) && (|$past(int_status & lie))));
  assert_mode_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    normal |=> (plv == 2'd0 && !ie));
  assert_refill_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && refill_active) |=> (da && !pg && next_pc == $past(refill_entry)));
  assert_debug_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_brk |=> (dbg_active && dbg_code == 6'hC && next_pc == $past(entry_base) + DBG_OFS));
  assert_redirect_marks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> redirect);
endmodule

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NIRQ = 8;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] RFE  = 32'h0020_0000;

  logic clk = 0, rst_n = 0;
  logic exc_req = 0, refill_active = 0, dbg_brk = 0;
  logic [5:0] exc_code = 0;
  logic [8:0] exc_sub = 0;
  logic [NIRQ-1:0] irq_lines = 0;
  logic [31:0] cur_pc = 0, fetch_word = 0;
  logic mode_we = 0, mode_ie = 0, mode_da = 0, mode_pg = 0, cfg_we = 0;
  logic [1:0] mode_plv = 0;
  logic [2:0] cfg_vs = 0;
  logic [NIRQ-1:0] cfg_lie = 0;

  logic redirect, irq_taken, ie, da, pg, saved_ie, rf_saved_ie;
  logic dbg_active, dbg_cause_brk, dbg_cause_int;
  logic [31:0] next_pc, ret_addr, bad_addr, bad_instr, rf_ret, dbg_ret;
  logic [1:0] plv, saved_plv, rf_saved_plv;
  logic [2:0] vs;
  logic [NIRQ-1:0] lie, int_status;
  logic [5:0] cause, dbg_code;
  logic [8:0] subcause;

  int vectors = 0, miscompares = 0;
  logic [31:0] m_badv = 0, m_badi = 0, m_era = 0;
  logic [5:0] m_cause = 0;

  trap_entry_unit dut (
    .clk, .rst_n, .exc_req, .exc_code, .exc_sub, .refill_active, .dbg_brk,
    .irq_lines, .cur_pc, .fetch_word, .entry_base(BASE), .refill_entry(RFE),
    .mode_we, .mode_plv, .mode_ie, .mode_da, .mode_pg, .cfg_we, .cfg_vs, .cfg_lie,
    .redirect, .irq_taken, .next_pc, .plv, .ie, .da, .pg, .vs, .lie, .int_status,
    .cause, .subcause, .saved_plv, .saved_ie, .ret_addr, .bad_addr, .bad_instr,
    .rf_saved_plv, .rf_saved_ie, .rf_ret, .dbg_active, .dbg_cause_brk,
    .dbg_cause_int, .dbg_code, .dbg_ret);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic setup(logic [1:0] p, logic e, logic [2:0] v, logic [NIRQ-1:0] l);
    mode_we = 1; mode_plv = p; mode_ie = e; mode_da = 0; mode_pg = 1;
    cfg_we = 1; cfg_vs = v; cfg_lie = l;
    @(negedge clk);
    mode_we = 0; cfg_we = 0;
  endtask

  function automatic logic [31:0] sp(logic [2:0] v);
    return (v == 0) ? 32'd0 : (32'd4 << v);
  endfunction

  task automatic run_irq(logic [2:0] v, logic [NIRQ-1:0] l, logic [NIRQ-1:0] lines,
                         logic e, logic [31:0] pc);
    logic [NIRQ-1:0] en;
    int hi;
    setup(2'd3, e, v, l);
    cur_pc = pc; irq_lines = lines;
    @(negedge clk);
    check("R2 status follows lines", int_status, lines);
    @(negedge clk);
    en = lines & l; hi = 0;
    for (int i = 0; i < NIRQ; i++) if (en[i]) hi = i;
    if (e && en != 0) begin
      check("R3 taken", irq_taken, 1);
      check("R4/R5 vector pc", next_pc, BASE + (32'd64 + hi) * sp(v));
      check("R5 cause zero", cause, 0);
      check("R6 saved mode", {saved_plv, saved_ie}, {2'd3, 1'b1});
      check("R6 ret addr", ret_addr, pc);
      check("R7 cleared", {plv, ie}, 3'b000);
      check("R8 badv kept", bad_addr, m_badv);
      check("R9 badi kept", bad_instr, m_badi);
      m_era = pc; m_cause = 0;
    end else begin
      check("R3 not taken", {irq_taken, redirect}, 2'b00);
      check("R3 mode kept", {plv, ie}, {2'd3, e});
    end
    irq_lines = 0;
    @(negedge clk);
    check("R2 no latching", int_status, 0);
    @(negedge clk);
  endtask

  task automatic run_exc(logic [5:0] c, logic [8:0] s);
    logic [31:0] pc;
    setup(2'd2, 1, 3'd2, 0);
    pc = 32'h8000_0000 + {c, 8'h00} + {s, 2'b00};
    cur_pc = pc; fetch_word = 32'hA500_0000 | {c, 8'h00} | s;
    exc_req = 1; exc_code = c; exc_sub = s;
    @(negedge clk);
    exc_req = 0;
    if (c >= 11 && c <= 18) m_badv = pc;
    if (!(c == 0 || c == 3 || (c == 8 && s == 0))) m_badi = fetch_word;
    m_era = pc; m_cause = c;
    check("R6 entry pc", next_pc, BASE + c * 32'd16);
    check("R13 redirect", redirect, 1);
    check("R6 cause", {cause, subcause}, {c, s});
    check("R6 saved", {saved_plv, saved_ie, ret_addr}, {2'd2, 1'b1, pc});
    check("R7 cleared", {plv, ie}, 3'b000);
    check("R8 bad addr", bad_addr, m_badv);
    check("R9 bad instr", bad_instr, m_badi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc", next_pc, 32'h1C00_0000);
    check("R1 mode", {plv, ie, da, pg}, 5'b00010);
    check("R1 cfg", {vs, lie}, 0);
    check("R1 flags", {redirect, irq_taken, dbg_active}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 8; v++)
      for (int k = 0; k < NIRQ; k++)
        run_irq(3'(v), 8'hFF, 8'((1 << k) | (((1 << k) - 1) & 8'h55)), 1,
                32'h4000_0000 + v * 64 + k * 4);
    run_irq(3'd1, 8'h3C, 8'hF0, 1, 32'h4100_0000);
    run_irq(3'd1, 8'h00, 8'hFF, 1, 32'h4100_0010);
    run_irq(3'd1, 8'hFF, 8'hFF, 0, 32'h4100_0020);

    for (int c = 0; c <= 18; c++)
      for (int s = 0; s < 2; s++)
        run_exc(6'(c), 9'(s));

    // R10 refill path
    setup(2'd2, 1, 3'd2, 0);
    refill_active = 1; cur_pc = 32'h5000_0010; exc_req = 1; exc_code = 1; exc_sub = 0;
    @(negedge clk);
    exc_req = 0; refill_active = 0;
    check("R10 entry", next_pc, RFE);
    check("R10 saved", {rf_saved_plv, rf_saved_ie}, {2'd2, 1'b1});
    check("R10 da pg", {da, pg}, 2'b10);
    check("R10 ret", rf_ret, 32'h5000_0010 >> 2);
    check("R10 normal untouched", {cause, ret_addr}, {m_cause, m_era});
    check("R7 refill clears", {plv, ie}, 3'b000);

    // R13 exception beats interrupt in same cycle
    setup(2'd1, 1, 3'd1, 8'hFF);
    cur_pc = 32'h6000_0000; irq_lines = 8'h04;
    @(negedge clk);
    exc_req = 1; exc_code = 13; exc_sub = 0; fetch_word = 32'h1234_5678;
    @(negedge clk);
    exc_req = 0; irq_lines = 0;
    m_badv = cur_pc; m_badi = fetch_word; m_era = cur_pc; m_cause = 13;
    check("R13 exc wins", {irq_taken, cause}, {1'b0, 6'd13});
    check("R13 exc pc", next_pc, BASE + 13 * 32'd8);
    @(negedge clk);
    check("R13 no late irq", irq_taken, 0);

    // R13 breakpoint beats exception
    setup(2'd3, 1, 3'd0, 8'hFF);
    cur_pc = 32'h7000_0000; dbg_brk = 1; exc_req = 1; exc_code = 11;
    @(negedge clk);
    dbg_brk = 0; exc_req = 0;
    check("R11 debug pc", next_pc, BASE + 32'h480);
    check("R11 flags", {dbg_active, dbg_cause_brk, dbg_code}, {1'b1, 1'b1, 6'hC});
    check("R11 dbg ret", dbg_ret, 32'h7000_0000);
    check("R11 mode kept", {plv, ie}, {2'd3, 1'b1});
    check("R13 brk wins cause", {cause, bad_addr}, {m_cause, m_badv});

    // R12 interrupt in debug state
    cur_pc = 32'h7000_0100; irq_lines = 8'h02;
    @(negedge clk);
    @(negedge clk);
    irq_lines = 0;
    check("R12 dei", {dbg_cause_int, irq_taken, redirect}, 3'b101);
    check("R12 pc", next_pc, BASE + 32'h480);
    check("R12 dbg ret", dbg_ret, 32'h7000_0100);
    check("R12 normal untouched", {cause, ret_addr, plv, ie}, {m_cause, m_era, 2'd3, 1'b1});
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule